// File: doc/BRIEF.md
# Decimal Square-Root Remainder Step

This block carries out one iteration of a radix-10 digit-recurrence square root. The caller supplies the current partial root Q, an already chosen signed root digit q in the range -5 to +5, the shifted remainder 10w of the current iteration, and the iteration index i. On a start strobe the block registers two results. The first is the next remainder w' = 10w - (2q·Q + q²·10^-(i+1)). The second is the extended root Q' = Q + q·10^-(i+1). Choosing the digit, setting up the first iteration and the final rounding and conversion are left to the surrounding logic.

All operands are fixed-point signed-digit vectors of W = NDIG+3 decimal digits. Each digit is a 4-bit two's-complement value. Digit p is packed at bits [4·(W-1-p)+3 : 4·(W-1-p)], so digit 0 is the most significant. Digit p has weight 10^(1-p): digit 0 is the tens position, digit 1 the units position, and digit p ≥ 2 the fractional position 10^-(p-1).

The term 2q·Q is formed as the sum of two addends. Each addend is taken from precomputed multiples of Q: ±2Q, ±4Q or ±10Q. The square q² is split as 10·C + S. C is placed in the lowest occupied digit of one addend and S in the empty digit just below it. A single signed-digit addition then yields the subtrahend, and a second one yields the remainder. The new root is formed by writing q into the first empty root digit.

Top module: `dsr_rem_step`

## Requirements
- R1: While rstN is low, and after it rises until the first start, nextRem and nextRoot read as all-zero digits and stepDone is low.
- R2: Without start, nextRem and nextRoot keep their values whatever the other inputs do.
- R3: stepDone is high in the cycle after each clock edge at which start was high, and low otherwise.
- R4: After a step, the value of nextRem equals value(remIn) - (2·q·value(rootIn) + q²·10^-(i+1)). Here q is digitIn as a signed integer, i is stepIdx, and value is the weighted digit sum defined above.
- R5: After a step, nextRoot equals rootIn with digit position stepIdx+2 replaced by digitIn, so its value is value(rootIn) + q·10^-(i+1). Every other digit is copied unchanged.
- R6: When rootIn digits lie in [-5,5] and remIn digits lie in [-6,6], every nextRem digit lies in [-6,6] and every nextRoot digit lies in [-5,5].
- R7: With q = 0, nextRem has the value of remIn and nextRoot has the value of rootIn.
- R8: The end digits q = +5 and q = -5 give the value of R4. These use the ten-times multiple and the largest square carry C = 2.
- R9: With rootIn = 1, remIn = -6.478014, q = -4 and i = 0, the results are nextRem = -0.078014 and nextRoot = 0.6.
- R10: The last index i = NDIG, with q landing in the least significant digit, gives the values of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Step strobe; results load on the next edge |
| rootIn | input | 4·W | Partial root Q; digits beyond position stepIdx+1 are zero |
| digitIn | input | 4 | Selected root digit q, two's complement, in [-5,5] |
| remIn | input | 4·W | Shifted remainder 10w, digits in [-6,6] |
| stepIdx | input | IDXW | Iteration index i, 0 to NDIG |
| nextRem | output | 4·W | Registered next remainder w' |
| nextRoot | output | 4·W | Registered next root Q' |
| stepDone | output | 1 | High for the cycle after a step |

## Verification
The hardest case to reach is a transfer that ripples through the redundant adders. In that case the subtrahend's digits come partly from the doubled multiples and partly from the inserted square carry, and they meet remainder digits at the ends of [-6,6]. The bench reaches it in three ways. It sweeps every digit value over one root. It feeds a remainder whose digits alternate between +6 and -6. It runs the last index, where the square digit lands in the least significant position and the carry lands in the one above it.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef logic signed [3:0] sdigit_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
  } dsr_ctrl_t;

  // digit sum split into a transfer to the next higher position and a low part
  typedef struct packed {
    logic [1:0] xfer;
    logic [3:0] low;
  } dsr_split_t;

  function automatic dsr_split_t splitSum(input logic signed [4:0] s);
    dsr_split_t r;
    logic signed [4:0] t5;
    if (s >= 5'sd5) begin
      r.xfer = 2'b01;
      t5 = s - 5'sd10;
    end else if (s <= -5'sd5) begin
      r.xfer = 2'b11;
      t5 = s + 5'sd10;
    end else begin
      r.xfer = 2'b00;
      t5 = s;
    end
    r.low = t5[3:0];
    return r;
  endfunction

  // q*q = 10*C + S, C in [0,2], S in [-5,5]
  function automatic logic [1:0] sqCarry(input logic [2:0] mag);
    case (mag)
      3'd3:    return 2'd1;
      3'd4:    return 2'd2;
      3'd5:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic sdigit_t sqDigit(input logic [2:0] mag);
    case (mag)
      3'd1:    return 4'sd1;
      3'd2:    return 4'sd4;
      3'd3:    return -4'sd1;
      3'd4:    return -4'sd4;
      3'd5:    return 4'sd5;
      default: return 4'sd0;
    endcase
  endfunction

endpackage

// File: rtl/dsr_sd_adder.sv
module dsr_sd_adder #(
  parameter int W = 10
) (
  input  logic [4*W-1:0] aVec,
  input  logic [4*W-1:0] bVec,
  output logic [4*W-1:0] sumVec
);
  import dsr_pkg::*;

  // xferIn[p] is the transfer arriving at digit p from digit p+1
  logic [1:0] xferIn [W+1];
  assign xferIn[W] = 2'b00;

  for (genvar p = 0; p < W; p++) begin : g_dig
    localparam int LSB = 4 * (W - 1 - p);
    logic signed [4:0] digSum;
    dsr_split_t part;
    assign digSum = {aVec[LSB+3], aVec[LSB +: 4]} + {bVec[LSB+3], bVec[LSB +: 4]};
    assign part = splitSum(digSum);
    assign sumVec[LSB +: 4] = part.low + {{2{xferIn[p+1][1]}}, xferIn[p+1]};
    if (p > 0) begin : g_up
      assign xferIn[p] = part.xfer;
    end else begin : g_top
      // transfer out of the tens digit cannot occur for bounded operands
      assign xferIn[0] = part.xfer;
    end
  end

endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output dsr_pkg::dsr_ctrl_t  ctrl,
  output logic                stepDone
);

  always_comb ctrl.loadEn = start & rstN;

  always_ff @(posedge clk) begin
    if (!rstN) stepDone <= 1'b0;
    else       stepDone <= start;
  end

endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath #(
  parameter int W    = 10,
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dsr_pkg::dsr_ctrl_t ctrl,
  input  logic [4*W-1:0]     rootIn,
  input  logic [3:0]         digitIn,
  input  logic [4*W-1:0]     remIn,
  input  logic [IDXW-1:0]    stepIdx,
  output logic [4*W-1:0]     nextRem,
  output logic [4*W-1:0]     nextRoot
);
  import dsr_pkg::*;

  logic [4*W-1:0] twoQ, fourQ, tenQ;
  logic [4*W-1:0] addU, addV, hatVec, negHat, remSum, rootNew;
  logic [2:0]     mag;
  logic           isNeg;
  logic [1:0]     carrySq;
  sdigit_t        digitSq;
  int             carryPos, digitPos;

  // easy multiples of the root
  dsr_sd_adder #(.W(W)) u_dbl1 (.aVec(rootIn), .bVec(rootIn), .sumVec(twoQ));
  dsr_sd_adder #(.W(W)) u_dbl2 (.aVec(twoQ),   .bVec(twoQ),   .sumVec(fourQ));
  assign tenQ = {rootIn[4*W-5:0], 4'b0000};

  assign isNeg    = digitIn[3];
  assign mag      = isNeg ? 3'(4'(-signed'(digitIn))) : digitIn[2:0];
  assign carrySq  = sqCarry(mag);
  assign digitSq  = sqDigit(mag);
  assign carryPos = int'(stepIdx) + 1;
  assign digitPos = int'(stepIdx) + 2;

  for (genvar p = 0; p < W; p++) begin : g_sel
    localparam int LSB = 4 * (W - 1 - p);
    sdigit_t m2, m4, m10, uRaw, vRaw, uSgn, vSgn;
    assign m2  = twoQ[LSB +: 4];
    assign m4  = fourQ[LSB +: 4];
    assign m10 = tenQ[LSB +: 4];

    // 2|q| = u + v with u,v taken from {0, 2, 4, 10}
    always_comb begin
      case (mag)
        3'd5:    begin uRaw = m10; vRaw = '0; end
        3'd4:    begin uRaw = m4;  vRaw = m4; end
        3'd3:    begin uRaw = m4;  vRaw = m2; end
        3'd2:    begin uRaw = m4;  vRaw = '0; end
        3'd1:    begin uRaw = m2;  vRaw = '0; end
        default: begin uRaw = '0;  vRaw = '0; end
      endcase
      uSgn = isNeg ? -uRaw : uRaw;
      vSgn = isNeg ? -vRaw : vRaw;
    end

    // square carry joins the even lowest digit of U, square digit the empty slot of V
    assign addU[LSB +: 4] = uSgn + ((p == carryPos) ? sdigit_t'({2'b00, carrySq}) : 4'sd0);
    assign addV[LSB +: 4] = vSgn + ((p == digitPos) ? digitSq : 4'sd0);
    assign negHat[LSB +: 4] = -hatVec[LSB +: 4];
    assign rootNew[LSB +: 4] = (p == digitPos) ? digitIn : rootIn[LSB +: 4];
  end

  dsr_sd_adder #(.W(W)) u_hat (.aVec(addU),  .bVec(addV),   .sumVec(hatVec));
  dsr_sd_adder #(.W(W)) u_rem (.aVec(remIn), .bVec(negHat), .sumVec(remSum));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextRem  <= '0;
      nextRoot <= '0;
    end else if (ctrl.loadEn) begin
      nextRem  <= remSum;
      nextRoot <= rootNew;
    end
  end

endmodule

// File: rtl/dsr_rem_step.sv
module dsr_rem_step #(
  parameter int NDIG = 7,
  localparam int W    = NDIG + 3,
  localparam int IDXW = $clog2(NDIG + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [4*W-1:0]    rootIn,
  input  logic [3:0]        digitIn,
  input  logic [4*W-1:0]    remIn,
  input  logic [IDXW-1:0]   stepIdx,
  output logic [4*W-1:0]    nextRem,
  output logic [4*W-1:0]    nextRoot,
  output logic              stepDone
);

  dsr_pkg::dsr_ctrl_t ctrl;

  dsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctrl(ctrl), .stepDone(stepDone)
  );

  dsr_datapath #(.W(W), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .rootIn(rootIn), .digitIn(digitIn), .remIn(remIn), .stepIdx(stepIdx),
    .nextRem(nextRem), .nextRoot(nextRoot)
  );

endmodule

// File: rtl/dsr_rem_step_chk.sv
module dsr_rem_step_chk #(
  parameter int NDIG = 7,
  localparam int W    = NDIG + 3,
  localparam int IDXW = $clog2(NDIG + 3)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [4*W-1:0]    rootIn,
  input logic [3:0]        digitIn,
  input logic [4*W-1:0]    remIn,
  input logic [IDXW-1:0]   stepIdx,
  input logic [4*W-1:0]    nextRem,
  input logic [4*W-1:0]    nextRoot,
  input logic              stepDone
);

  function automatic logic remInRange(input logic [4*W-1:0] v);
    for (int p = 0; p < W; p++) begin
      if ($signed(v[4*p +: 4]) > 4'sd6 || $signed(v[4*p +: 4]) < -4'sd6) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic rootFormed(input logic [4*W-1:0] oldV, input logic [4*W-1:0] newV,
                                      input logic [IDXW-1:0] idx, input logic [3:0] dig);
    for (int p = 0; p < W; p++) begin
      if (p == int'(idx) + 2) begin
        if (newV[4*(W-1-p) +: 4] != dig) return 1'b0;
      end else if (newV[4*(W-1-p) +: 4] != oldV[4*(W-1-p) +: 4]) begin
        return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> stepDone) else $error("AST_DONE_AFTER_START"); // R3
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> $past(start)) else $error("AST_DONE_NEEDS_START"); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(nextRem) && $stable(nextRoot))) else $error("AST_HOLD_IDLE"); // R2
  AST_ROOT_FORMED: assert property (@(posedge clk) disable iff (!rstN)
    start |=> rootFormed($past(rootIn), nextRoot, $past(stepIdx), $past(digitIn)))
    else $error("AST_ROOT_FORMED"); // R5
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (start && remInRange(remIn)) |=> remInRange(nextRem)) else $error("AST_REM_RANGE"); // R6

endmodule

bind dsr_rem_step dsr_rem_step_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/dsr_rem_step_bench.sv
`timescale 1ns/1ps
module dsr_rem_step_bench;
  localparam int NDIG = 7;
  localparam int W    = NDIG + 3;
  localparam int IDXW = $clog2(NDIG + 3);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [4*W-1:0]    rootIn = '0;
  logic [3:0]        digitIn = '0;
  logic [4*W-1:0]    remIn = '0;
  logic [IDXW-1:0]   stepIdx = '0;
  logic [4*W-1:0]    nextRem, nextRoot;
  logic              stepDone;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dsr_rem_step #(.NDIG(NDIG)) u_dsr_rem_step (
    .clk(clk), .rstN(rstN), .start(start), .rootIn(rootIn), .digitIn(digitIn),
    .remIn(remIn), .stepIdx(stepIdx), .nextRem(nextRem), .nextRoot(nextRoot),
    .stepDone(stepDone)
  );

  function automatic longint pow10(input int e);
    longint r = 1;
    for (int k = 0; k < e; k++) r = r * 10;
    return r;
  endfunction

  // scaled integer (units of 10^-(W-2)) to balanced digits in [-5,5]
  function automatic logic [4*W-1:0] toVec(input longint v);
    logic [4*W-1:0] r = '0;
    longint x = v;
    for (int p = W - 1; p >= 0; p--) begin
      longint d = x % 10;
      if (d > 5) d = d - 10;
      if (d < -5) d = d + 10;
      r[4*(W-1-p) +: 4] = 4'(d);
      x = (x - d) / 10;
    end
    return r;
  endfunction

  function automatic int digAt(input logic [4*W-1:0] v, input int p);
    return int'($signed(v[4*(W-1-p) +: 4]));
  endfunction

  function automatic longint toVal(input logic [4*W-1:0] v);
    longint s = 0;
    for (int p = 0; p < W; p++) s = s + longint'(digAt(v, p)) * pow10(W - 1 - p);
    return s;
  endfunction

  function automatic bit rangeOk(input logic [4*W-1:0] v, input int lim);
    for (int p = 0; p < W; p++) if (digAt(v, p) > lim || digAt(v, p) < -lim) return 0;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one step with full checking of value, digits and strobe
  task automatic runStep(input longint rootS, input int q, input logic [4*W-1:0] remV,
                         input int idx, input string req);
    logic [4*W-1:0] rootV = toVec(rootS);
    longint expRem  = toVal(remV) - (2 * q * toVal(rootV) + q * q * pow10(W - 2 - (idx + 1)));
    longint expRoot = toVal(rootV) + q * pow10(W - 2 - (idx + 1));
    bit kept = 1;
    @(negedge clk);
    rootIn = rootV; digitIn = 4'(q); remIn = remV; stepIdx = IDXW'(idx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(toVal(nextRem) == expRem, {req, " R4 remainder"}, toVal(nextRem), expRem);
    check(toVal(nextRoot) == expRoot, {req, " R5 root"}, toVal(nextRoot), expRoot);
    for (int p = 0; p < W; p++)
      if (p != idx + 2 && digAt(nextRoot, p) != digAt(rootV, p)) kept = 0;
    check(kept && digAt(nextRoot, idx + 2) == q, {req, " R5 digits"}, longint'(digAt(nextRoot, idx + 2)), longint'(q));
    check(rangeOk(nextRem, 6) && rangeOk(nextRoot, 5), {req, " R6 ranges"}, 0, 1);
    check(stepDone == 1'b1, {req, " R3 done high"}, longint'(stepDone), 1);
    @(negedge clk);
    check(stepDone == 1'b0, {req, " R3 done low"}, longint'(stepDone), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(nextRem == '0 && nextRoot == '0 && stepDone == 1'b0, "R1 during reset", toVal(nextRem), 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check(nextRem == '0 && nextRoot == '0 && stepDone == 1'b0, "R1 after reset", toVal(nextRoot), 0);
  endtask

  task automatic testReference();
    runStep(longint'(100000000), -4, toVec(-647801400), 0, "R9");
    check(toVal(nextRem) == -7801400, "R9 w1", toVal(nextRem), -7801400);
    check(toVal(nextRoot) == 60000000, "R9 Q1", toVal(nextRoot), 60000000);
  endtask

  task automatic testHold();
    longint r0 = toVal(nextRem);
    longint q0 = toVal(nextRoot);
    @(negedge clk);
    rootIn = toVec(12345678); digitIn = 4'(3); remIn = toVec(-222222222); stepIdx = 1;
    repeat (4) @(negedge clk);
    check(toVal(nextRem) == r0, "R2 remainder held", toVal(nextRem), r0);
    check(toVal(nextRoot) == q0, "R2 root held", toVal(nextRoot), q0);
  endtask

  task automatic testSweep();
    for (int q = -5; q <= 5; q++) runStep(longint'(57000000), q, toVec(314159265), 2, "R4 sweep");
  endtask

  task automatic testZeroDigit();
    runStep(longint'(73000000), 0, toVec(-512345678), 2, "R7");
    check(toVal(nextRem) == -512345678, "R7 remainder unchanged value", toVal(nextRem), -512345678);
    check(toVal(nextRoot) == 73000000, "R7 root unchanged value", toVal(nextRoot), 73000000);
  endtask

  task automatic testEndDigits();
    runStep(longint'(100000000), 5, toVec(460000000), 0, "R8 plus five");
    runStep(longint'(100000000), -5, toVec(-460000000), 0, "R8 minus five");
    runStep(longint'(98000000), 5, toVec(-98765432), 2, "R8 plus five deep");
  endtask

  task automatic testRedundantRem();
    logic [4*W-1:0] v = '0;
    for (int p = 1; p < W; p++) v[4*(W-1-p) +: 4] = (p % 2 == 1) ? 4'sd6 : -4'sd6;
    runStep(longint'(45000000), 4, v, 2, "R6 alternating");
    runStep(longint'(45000000), -5, v, 2, "R6 alternating neg");
  endtask

  task automatic testLastIndex();
    runStep(longint'(59346320), 3, toVec(267631000), NDIG, "R10 plus");
    runStep(longint'(59346320), -4, toVec(-432100000), NDIG, "R10 minus");
  endtask

  initial begin
    testReset();
    testReference();
    testHold();
    testSweep();
    testZeroDigit();
    testEndDigits();
    testRedundantRem();
    testLastIndex();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule